// File: doc/BRIEF.md
# Overvoltage Crowbar Latch Controller

This block watches a set of digitized comparator flags for one output rail and decides, every clock, what each phase of a multi-phase PWM output bank may do. In normal operation each phase output follows its PWM request. While the bias supply is not yet good, every phase sits in high-impedance. When an overvoltage flag arrives, the block latches a fault and pulls every phase low. The low-side switches then crowbar the rail.

Once the rail has fallen back to its target level, the phases are released to high-impedance, so both switches of each phase are off. A fresh overvoltage while latched pulls them low again, and this low/release cycle repeats for as long as the fault recurs. Normal modulation stays suppressed until the bias-good flag falls and rises again. The overvoltage and at-target flags are asynchronous to the block clock, so each passes through a two-flop synchronizer. Each phase is driven as an enable bit plus a data bit.

Top module: `ovp_crowbar_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all phases become high-impedance (`phase_oe` = 0, `phase_dat` = 0), and `fault_latched` and `crowbar_low` become 0.
- R2: A clock edge that samples `bias_good` low makes every phase high-impedance and clears the fault latch after that edge.
- R3: With `bias_good` high and no fault latched, each phase drives its request one cycle later: `phase_oe` = all ones and `phase_dat` = `pwm_req` as sampled at the previous edge.
- R4: An overvoltage flag sampled at edge k sets `fault_latched` and `crowbar_low` after edge k+2. After edge k+3, every phase drives low (`phase_oe` = 1, `phase_dat` = 0), overriding `pwm_req`.
- R5: While `crowbar_low` is set, an at-target flag reaching the fault logic with no overvoltage clears `crowbar_low`, and the phases go high-impedance on the following edge. The at-target flag has the same two-edge synchronizer delay as the overvoltage flag.
- R6: While latched and released, a new overvoltage pulls all phases low again with the R4 latency. The low/release cycle repeats without limit.
- R7: Once latched, `fault_latched` stays 1 and `phase_dat` stays 0 for any `pwm_req`, for as long as `bias_good` stays high.
- R8: When the synchronized overvoltage and at-target flags are both high in the same cycle, overvoltage wins and the phases are held or forced low.
- R9: Phase encoding: `phase_oe[i]` = 0 means high-impedance and `phase_dat[i]` = 0. `phase_oe[i]` = 1 means the phase drives `phase_dat[i]`. `crowbar_low` = 1 means the latched fault is in its pull-low state, and `crowbar_low` = 0 with `fault_latched` = 1 means the released state.
- R10: If an overvoltage is already present when `bias_good` rises, the block enters the pull-low state directly and never drives a PWM request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bias_good | input | 1 | Bias supply above its power-on threshold (synchronous flag) |
| ov_flag | input | 1 | Overvoltage comparator output (asynchronous) |
| at_target | input | 1 | Output at or below target level (asynchronous) |
| pwm_req | input | NUM_PHASES | Normal PWM drive request per phase |
| phase_oe | output | NUM_PHASES | Per-phase drive enable; 0 = high-impedance |
| phase_dat | output | NUM_PHASES | Per-phase drive level when enabled |
| fault_latched | output | 1 | Overvoltage fault is latched |
| crowbar_low | output | 1 | Latched fault is in its pull-low state |

## Verification
Two events can arrive in the same cycle: the overvoltage flag that pulls phases low and the at-target flag that releases them. A third collision is a bias power cycle that lands while an overvoltage is still present. The bench raises both comparator flags on the same edge, both while in the pull-low state and while released, and it brings bias good back up with the overvoltage already high. It judges each outcome against a cycle-level model that counts the two synchronizer stages, the fault register and the output register. A long run with a fixed seed then mixes rare overvoltage pulses, frequent at-target levels and occasional bias drops, so these coincidences recur.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_RUN    = 2'd1,
    MODE_CB_LOW = 2'd2,
    MODE_CB_HIZ = 2'd3
  } ovp_mode_e;
endpackage

// File: rtl/ovp_sync.sv
module ovp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/ovp_fault_fsm.sv
module ovp_fault_fsm
  import ovp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bias_good,
  input  logic      ov_s,
  input  logic      tgt_s,
  output ovp_mode_e mode,
  output logic      fault_latched,
  output logic      crowbar_low
);
  ovp_mode_e mode_nx;

  always_comb begin
    mode_nx = mode;
    if (!bias_good) begin
      mode_nx = MODE_OFF;
    end else begin
      unique case (mode)
        MODE_OFF:    mode_nx = ov_s ? MODE_CB_LOW : MODE_RUN;
        MODE_RUN:    mode_nx = ov_s ? MODE_CB_LOW : MODE_RUN;
        MODE_CB_LOW: mode_nx = ov_s ? MODE_CB_LOW : (tgt_s ? MODE_CB_HIZ : MODE_CB_LOW);
        MODE_CB_HIZ: mode_nx = ov_s ? MODE_CB_LOW : MODE_CB_HIZ;
        default:     mode_nx = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode          <= MODE_OFF;
      fault_latched <= 1'b0;
      crowbar_low   <= 1'b0;
    end else begin
      mode          <= mode_nx;
      fault_latched <= (mode_nx == MODE_CB_LOW) || (mode_nx == MODE_CB_HIZ);
      crowbar_low   <= (mode_nx == MODE_CB_LOW);
    end
  end
endmodule

// File: rtl/ovp_phase_drive.sv
module ovp_phase_drive
  import ovp_pkg::*;
#(
  parameter int NUM_PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bias_good,
  input  ovp_mode_e             mode,
  input  logic [NUM_PHASES-1:0] pwm_req,
  output logic [NUM_PHASES-1:0] phase_oe,
  output logic [NUM_PHASES-1:0] phase_dat
);
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    always_ff @(posedge clk) begin
      if (rst || !bias_good) begin
        phase_oe[p]  <= 1'b0;
        phase_dat[p] <= 1'b0;
      end else begin
        unique case (mode)
          MODE_RUN: begin
            phase_oe[p]  <= 1'b1;
            phase_dat[p] <= pwm_req[p];
          end
          MODE_CB_LOW: begin
            phase_oe[p]  <= 1'b1;
            phase_dat[p] <= 1'b0;
          end
          default: begin
            phase_oe[p]  <= 1'b0;
            phase_dat[p] <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ovp_crowbar_ctrl.sv
module ovp_crowbar_ctrl
  import ovp_pkg::*;
#(
  parameter int NUM_PHASES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bias_good,
  input  logic                  ov_flag,
  input  logic                  at_target,
  input  logic [NUM_PHASES-1:0] pwm_req,
  output logic [NUM_PHASES-1:0] phase_oe,
  output logic [NUM_PHASES-1:0] phase_dat,
  output logic                  fault_latched,
  output logic                  crowbar_low
);
  localparam int FLAG_W = 2;

  logic [FLAG_W-1:0] flags_raw;
  logic [FLAG_W-1:0] flags_s;
  ovp_mode_e         mode;

  assign flags_raw = {at_target, ov_flag};

  ovp_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (flags_raw),
    .q_sync  (flags_s)
  );

  ovp_fault_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .bias_good     (bias_good),
    .ov_s          (flags_s[0]),
    .tgt_s         (flags_s[1]),
    .mode          (mode),
    .fault_latched (fault_latched),
    .crowbar_low   (crowbar_low)
  );

  ovp_phase_drive #(.NUM_PHASES(NUM_PHASES)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .bias_good (bias_good),
    .mode      (mode),
    .pwm_req   (pwm_req),
    .phase_oe  (phase_oe),
    .phase_dat (phase_dat)
  );
endmodule

// File: rtl/ovp_crowbar_chk.sv
module ovp_crowbar_chk #(
  parameter int NUM_PHASES = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bias_good,
  input logic [NUM_PHASES-1:0] phase_oe,
  input logic [NUM_PHASES-1:0] phase_dat,
  input logic                  fault_latched,
  input logic                  crowbar_low
);
  assert_bias_low_hiz_R2: assert property (@(posedge clk) disable iff (rst)
    !bias_good |=> (phase_oe == '0) && !fault_latched);

  assert_low_drives_R4: assert property (@(posedge clk) disable iff (rst)
    crowbar_low && bias_good |=> (phase_oe == '1) && (phase_dat == '0));

  assert_release_hiz_R5: assert property (@(posedge clk) disable iff (rst)
    fault_latched && !crowbar_low && bias_good |=> (phase_oe == '0));

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (rst)
    fault_latched && bias_good |=> fault_latched);

  assert_no_pwm_in_fault_R7: assert property (@(posedge clk) disable iff (rst)
    fault_latched |=> (phase_dat == '0));

  assert_hiz_data_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ((phase_dat & ~phase_oe) == '0));
endmodule

bind ovp_crowbar_ctrl ovp_crowbar_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .bias_good     (bias_good),
  .phase_oe      (phase_oe),
  .phase_dat     (phase_dat),
  .fault_latched (fault_latched),
  .crowbar_low   (crowbar_low)
);

// File: tb/ovp_crowbar_ctrl_bench.sv
`timescale 1ns/1ps
module ovp_crowbar_ctrl_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         bias_good;
  logic         ov_flag;
  logic         at_target;
  logic [N-1:0] pwm_req;
  logic [N-1:0] phase_oe;
  logic [N-1:0] phase_dat;
  logic         fault_latched;
  logic         crowbar_low;

  int checks = 0;
  int errors = 0;
  string dir_tag = "";

  // model state
  bit           m_s1o, m_s2o, m_s1t, m_s2t;
  int           m_mode;   // 0 off, 1 run, 2 pull-low, 3 released
  bit [N-1:0]   m_oe, m_dat;
  string        m_tag;

  always #2.5 clk = ~clk;

  ovp_crowbar_ctrl #(.NUM_PHASES(N)) u_ovp_crowbar_ctrl (
    .clk(clk), .rst(rst), .bias_good(bias_good), .ov_flag(ov_flag),
    .at_target(at_target), .pwm_req(pwm_req), .phase_oe(phase_oe),
    .phase_dat(phase_dat), .fault_latched(fault_latched), .crowbar_low(crowbar_low)
  );

  function automatic int next_mode(int md, bit bg, bit o, bit t);
    if (!bg) return 0;
    case (md)
      0, 1:    return o ? 2 : 1;
      2:       return o ? 2 : (t ? 3 : 2);
      default: return o ? 2 : 3;
    endcase
  endfunction

  task automatic model_update();
    if (rst) begin
      m_s1o = 0; m_s2o = 0; m_s1t = 0; m_s2t = 0;
      m_mode = 0; m_oe = '0; m_dat = '0; m_tag = "R1";
    end else begin
      if (!bias_good) begin
        m_oe = '0; m_dat = '0;
      end else if (m_mode == 1) begin
        m_oe = '1; m_dat = pwm_req;
      end else if (m_mode == 2) begin
        m_oe = '1; m_dat = '0;
      end else begin
        m_oe = '0; m_dat = '0;
      end
      m_mode = next_mode(m_mode, bias_good, m_s2o, m_s2t);
      m_s2o = m_s1o; m_s1o = ov_flag;
      m_s2t = m_s1t; m_s1t = at_target;
      if (!bias_good)       m_tag = "R2";
      else if (m_mode == 2) m_tag = "R4";
      else if (m_mode == 3) m_tag = "R5";
      else                  m_tag = "R3";
    end
  endtask

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string t;
    t = (dir_tag != "") ? dir_tag : m_tag;
    check(t, "phase_oe", phase_oe, m_oe);
    check(t, "phase_dat", phase_dat, m_dat);
    check(t, "fault_latched", {{(N-1){1'b0}}, fault_latched}, {{(N-1){1'b0}}, 1'(m_mode >= 2)});
    check(t, "crowbar_low", {{(N-1){1'b0}}, crowbar_low}, {{(N-1){1'b0}}, 1'(m_mode == 2)});
  endtask

  task automatic cycle();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    rst = 1; bias_good = 0; ov_flag = 0; at_target = 0; pwm_req = '0;
    dir_tag = "R1";
    cycles(3);
    rst = 0;
    dir_tag = "R2";                 // bias still low: phases stay high-impedance
    cycles(2);
    bias_good = 1;
    dir_tag = "R3";                 // normal drive with several request patterns
    pwm_req = 4'b1010; cycle();
    pwm_req = 4'b0101; cycle();
    pwm_req = 4'b1111; cycle();
    pwm_req = 4'b0000; cycle();
    pwm_req = 4'b1001; cycles(2);
    dir_tag = "R4";                 // single overvoltage pulse, latency through sync
    ov_flag = 1; cycle();
    ov_flag = 0; cycles(5);
    dir_tag = "R5";                 // back at target: release
    at_target = 1; cycles(5);
    dir_tag = "R8";                 // both flags together while released: low wins
    ov_flag = 1; cycles(4);
    ov_flag = 0; cycles(4);
    dir_tag = "R6";                 // recurring fault cycles again
    at_target = 0; ov_flag = 1; cycles(3);
    ov_flag = 0; at_target = 1; cycles(4);
    dir_tag = "R7";                 // requests ignored while latched
    for (int i = 0; i < 8; i++) begin pwm_req = 4'(i * 3 + 1); cycle(); end
    dir_tag = "R9";
    at_target = 0; ov_flag = 1; cycles(4); ov_flag = 0; cycles(2);
    dir_tag = "R2";                 // bias drop clears latch
    bias_good = 0; cycles(3);
    dir_tag = "R3";
    bias_good = 1; pwm_req = 4'b0110; cycles(6);
    dir_tag = "R10";                // bias returns with overvoltage present
    bias_good = 0; ov_flag = 1; cycles(4);
    bias_good = 1; cycles(5);
    ov_flag = 0; bias_good = 0; cycles(2); bias_good = 1; cycles(2);
    dir_tag = "";
    for (int i = 0; i < 4000; i++) begin
      pwm_req   = N'($urandom);
      ov_flag   = ($urandom % 50) == 0;
      at_target = ($urandom % 4) == 0;
      if (($urandom % 200) == 0) bias_good = ~bias_good;
      else if (!bias_good && ($urandom % 4) == 0) bias_good = 1;
      cycle();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule